// File: doc/BRIEF.md
# Floating-Point Issue Hazard Scoreboard

This block decides, cycle by cycle, whether the next decoded floating-point operation may enter a single floating-point execution unit. Each operation arrives on a valid/ready stream carrying an opcode, a destination register tag and up to two source register tags. The block never computes a value. It models each operation only by its latency and by the way it occupies the unit. It holds the operation at its input until every structural and data hazard is gone.

A small scoreboard keeps a busy flag and a countdown for each physical register. A per-register strobe marks the cycle in which a result first becomes readable. When an operation is held, a cause code reports the highest-priority reason, so a front end or a performance monitor can see why issue stopped.

Back-pressure rules: `in_ready` depends only on the registered state and on the operation fields at the input. An operation is accepted in any cycle where `in_valid` and `in_ready` are both high. The producer must hold the operation stable while `in_valid` is high and `in_ready` is low.

Top module: `fp_issue_scoreboard`

## Requirements
- R1: `issue_fire` is high exactly when `in_valid` and `in_ready` are both high. `stall` is high exactly when `in_valid` is high and `in_ready` is low. With `in_valid` low, `stall_cause` reads 0.
- R2: Opcodes are ADD=0, SUB=1, MUL=2, integer-load ILD=3, LD=4, DIV=5, ST=6. ADD, SUB, MUL and ILD have a latency of 3 cycles. An operation reading their destination may issue 3 cycles after the producer issued. Independent operations of these kinds may issue on consecutive cycles.
- R3: LD has a latency of 1 cycle, so a dependent operation may issue in the very next cycle.
- R4: A MUL cannot issue in the cycle right after another MUL issued.
- R5: After a DIV issues at cycle t, no operation issues in cycles t+1 through t+36. Another DIV cannot issue before t+39. The DIV result is readable at t+39.
- R6: An operation waits while a used source register, or its own destination register, has a result still in flight (read-after-write and write-after-write).
- R7: A ST reads its source `in_src_a`. It issues at cycle s only if that source became readable at cycle s-1 or earlier. ST writes no register.
- R8: In the cycle right after a ST issues, no operation issues.
- R9: `result_ready[i]` pulses high for exactly one cycle, the first cycle in which register i's result is readable.
- R10: `stall_cause` reports the first hazard in this order: 1 store occupancy, 2 divide block, 3 multiply back-to-back, 4 data hazard. 0 means no hazard.
- R11: A synchronous active-high `rst` clears every register countdown, strobe and unit counter. After reset, `result_ready` is 0 and any operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present at the input |
| in_ready | output | 1 | Operation may issue this cycle |
| in_op | input | 3 | Opcode (see R2) |
| in_dst | input | 3 | Destination register tag |
| in_src_a | input | 3 | First source register tag (ST data source) |
| in_src_b | input | 3 | Second source register tag |
| in_use_a | input | 1 | First source is read |
| in_use_b | input | 1 | Second source is read |
| issue_fire | output | 1 | Operation issues this cycle |
| stall | output | 1 | Operation present but held |
| stall_cause | output | 3 | Reason for holding (see R10) |
| result_ready | output | 8 | One-cycle strobe per register when its result becomes readable |

## Verification
`in_ready`, `issue_fire`, `stall` and `stall_cause` are due in the same cycle the operation is presented, because they are combinational over registered state. `result_ready[i]` is due exactly L cycles after the producer issued, where L is that operation's latency. The bench drives inputs on the falling edge and samples all outputs shortly after it. In every cycle it compares them with a timing model that records the issue cycles of the last multiply, store and divide and the ready cycle of each register. The timing model decides which cycle an operation issues in. It advances its state only on those predicted issues, so any early or late issue by the design appears as a mismatch within that same cycle.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_ILD = 3'd3,
    OP_LD  = 3'd4,
    OP_DIV = 3'd5,
    OP_ST  = 3'd6,
    OP_RSV = 3'd7
  } fp_op_e;

  typedef enum logic [2:0] {
    CZ_NONE  = 3'd0,
    CZ_STORE = 3'd1,
    CZ_DIV   = 3'd2,
    CZ_MUL   = 3'd3,
    CZ_DATA  = 3'd4
  } stall_cz_e;
endpackage

// File: rtl/fpsb_reg_slot.sv
module fpsb_reg_slot #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_i,
  input  logic [CW-1:0] lat_m1_i,
  output logic          busy_o,
  output logic          fresh_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      busy_o  <= 1'b0;
      fresh_o <= 1'b0;
    end else if (set_i) begin
      cnt     <= lat_m1_i;
      busy_o  <= (lat_m1_i != '0);
      fresh_o <= (lat_m1_i == '0);
    end else if (busy_o) begin
      cnt     <= cnt - CW'(1);
      busy_o  <= (cnt != CW'(1));
      fresh_o <= (cnt == CW'(1));
    end else begin
      fresh_o <= 1'b0;
    end
  end

  // R6: an in-flight result counts down by one each cycle
  a_r6_countdown: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !set_i && cnt > CW'(1)) |=> (busy_o && cnt == $past(cnt) - CW'(1)));

  // R9: the ready strobe lasts one cycle unless the register is rewritten
  a_r9_strobe_once: assert property (@(posedge clk) disable iff (rst)
    (fresh_o && !set_i) |=> !fresh_o);
endmodule

// File: rtl/fpsb_unit_occ.sv
module fpsb_unit_occ
  import fpsb_pkg::*;
#(
  parameter int DIV_LAT  = 39,
  parameter int DIV_TAIL = 2,
  parameter int CW       = 6
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   issue_i,
  input  fp_op_e op_i,
  output logic   st_blk_o,
  output logic   mul_prev_o,
  output logic   div_fp_blk_o,
  output logic   div_unit_busy_o
);
  logic [CW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt    <= '0;
      st_blk_o   <= 1'b0;
      mul_prev_o <= 1'b0;
    end else begin
      st_blk_o   <= issue_i && (op_i == OP_ST);
      mul_prev_o <= issue_i && (op_i == OP_MUL);
      if (issue_i && op_i == OP_DIV)
        div_cnt <= CW'(DIV_LAT - 1);
      else if (div_cnt != '0)
        div_cnt <= div_cnt - CW'(1);
    end
  end

  assign div_fp_blk_o    = (div_cnt > CW'(DIV_TAIL));
  assign div_unit_busy_o = (div_cnt != '0);

  // R8: nothing issues in the second execution cycle of a store
  a_r8_store_gap: assert property (@(posedge clk) disable iff (rst)
    st_blk_o |-> !issue_i);

  // R4: no multiply right after a multiply
  a_r4_mul_gap: assert property (@(posedge clk) disable iff (rst)
    mul_prev_o |-> !(issue_i && op_i == OP_MUL));

  // R5: divide blocks all issue until its final cycles
  a_r5_div_hold: assert property (@(posedge clk) disable iff (rst)
    div_fp_blk_o |-> !issue_i);
endmodule

// File: rtl/fpsb_hazard.sv
module fpsb_hazard
  import fpsb_pkg::*;
#(
  parameter int NREG = 8,
  parameter int TW   = 3
) (
  input  fp_op_e          op_i,
  input  logic [TW-1:0]   dst_i,
  input  logic [TW-1:0]   src_a_i,
  input  logic [TW-1:0]   src_b_i,
  input  logic            use_a_i,
  input  logic            use_b_i,
  input  logic [NREG-1:0] busy_i,
  input  logic [NREG-1:0] fresh_i,
  input  logic            st_blk_i,
  input  logic            mul_prev_i,
  input  logic            div_fp_blk_i,
  input  logic            div_unit_busy_i,
  output stall_cz_e       cause_o
);
  logic is_st, writes, raw_a, raw_b, waw, st_early, data_hit, div_hit;

  always_comb begin
    is_st    = (op_i == OP_ST);
    writes   = !is_st;
    raw_a    = use_a_i && busy_i[src_a_i];
    raw_b    = use_b_i && busy_i[src_b_i];
    waw      = writes && busy_i[dst_i];
    st_early = is_st && use_a_i && fresh_i[src_a_i];
    data_hit = raw_a || raw_b || waw || st_early;
    div_hit  = div_fp_blk_i || ((op_i == OP_DIV) && div_unit_busy_i);

    if (st_blk_i)                         cause_o = CZ_STORE;
    else if (div_hit)                     cause_o = CZ_DIV;
    else if (op_i == OP_MUL && mul_prev_i) cause_o = CZ_MUL;
    else if (data_hit)                    cause_o = CZ_DATA;
    else                                  cause_o = CZ_NONE;
  end
endmodule

// File: rtl/fp_issue_scoreboard.sv
module fp_issue_scoreboard
  import fpsb_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int ARITH_LAT = 3,
  parameter int LOAD_LAT  = 1,
  parameter int DIV_LAT   = 39,
  parameter int DIV_TAIL  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [2:0]                in_op,
  input  logic [$clog2(NREG)-1:0]   in_dst,
  input  logic [$clog2(NREG)-1:0]   in_src_a,
  input  logic [$clog2(NREG)-1:0]   in_src_b,
  input  logic                      in_use_a,
  input  logic                      in_use_b,
  output logic                      issue_fire,
  output logic                      stall,
  output logic [2:0]                stall_cause,
  output logic [NREG-1:0]           result_ready
);
  localparam int TW = $clog2(NREG);
  localparam int CW = $clog2(DIV_LAT + 1);

  fp_op_e        op;
  stall_cz_e     cause;
  logic [CW-1:0] lat_m1;
  logic [NREG-1:0] busy_vec, fresh_vec;
  logic st_blk, mul_prev, div_fp_blk, div_unit_busy;

  assign op = fp_op_e'(in_op);

  always_comb begin
    case (op)
      OP_LD:   lat_m1 = CW'(LOAD_LAT - 1);
      OP_DIV:  lat_m1 = CW'(DIV_LAT - 1);
      default: lat_m1 = CW'(ARITH_LAT - 1);
    endcase
  end

  fpsb_hazard #(.NREG(NREG), .TW(TW)) u_hazard (
    .op_i(op), .dst_i(in_dst), .src_a_i(in_src_a), .src_b_i(in_src_b),
    .use_a_i(in_use_a), .use_b_i(in_use_b),
    .busy_i(busy_vec), .fresh_i(fresh_vec),
    .st_blk_i(st_blk), .mul_prev_i(mul_prev),
    .div_fp_blk_i(div_fp_blk), .div_unit_busy_i(div_unit_busy),
    .cause_o(cause)
  );

  assign in_ready    = (cause == CZ_NONE);
  assign issue_fire  = in_valid && in_ready;
  assign stall       = in_valid && !in_ready;
  assign stall_cause = in_valid ? cause : CZ_NONE;

  fpsb_unit_occ #(.DIV_LAT(DIV_LAT), .DIV_TAIL(DIV_TAIL), .CW(CW)) u_occ (
    .clk(clk), .rst(rst), .issue_i(issue_fire), .op_i(op),
    .st_blk_o(st_blk), .mul_prev_o(mul_prev),
    .div_fp_blk_o(div_fp_blk), .div_unit_busy_o(div_unit_busy)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    logic set_i;
    assign set_i = issue_fire && (op != OP_ST) && (in_dst == TW'(i));
    fpsb_reg_slot #(.CW(CW)) u_slot (
      .clk(clk), .rst(rst), .set_i(set_i), .lat_m1_i(lat_m1),
      .busy_o(busy_vec[i]), .fresh_o(fresh_vec[i])
    );
  end

  assign result_ready = fresh_vec;

  // R1: a held operation never fires and a fired one is present
  a_r1_fire_valid: assert property (@(posedge clk) disable iff (rst)
    issue_fire |-> (in_valid && !stall));

  // R7: a store never issues in the cycle its source first becomes readable
  a_r7_store_early: assert property (@(posedge clk) disable iff (rst)
    (issue_fire && op == OP_ST && in_use_a) |-> !result_ready[in_src_a]);

  // R11: reset leaves no strobes and accepts the next operation
  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (result_ready == '0 && in_ready));
endmodule

// File: tb/fp_issue_scoreboard_test.sv
module fp_issue_scoreboard_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] in_op = 3'd0, in_dst = 3'd0, in_src_a = 3'd0, in_src_b = 3'd0;
  logic in_use_a = 1'b0, in_use_b = 1'b0;
  logic in_ready, issue_fire, stall;
  logic [2:0] stall_cause;
  logic [7:0] result_ready;

  fp_issue_scoreboard uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_use_a(in_use_a), .in_use_b(in_use_b), .issue_fire(issue_fire),
    .stall(stall), .stall_cause(stall_cause), .result_ready(result_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int rdy_t[8];
  int last_mul, last_st, last_div;

  function automatic void model_reset();
    for (int i = 0; i < 8; i++) rdy_t[i] = -100;
    last_mul = -100; last_st = -100; last_div = -1000;
  endfunction

  function automatic int op_lat(input int op);
    if (op == 4) return 1;
    if (op == 5) return 39;
    return 3;
  endfunction

  // expected stall cause from R4..R8 and priority R10
  function automatic int exp_cause(input int op, input int d, input int sa,
                                   input int sb, input bit ua, input bit ub, input int c);
    if (last_st == c - 1) return 1;
    if (c - last_div >= 1 && c - last_div <= 36) return 2;
    if (op == 5 && c - last_div <= 38) return 2;
    if (op == 2 && last_mul == c - 1) return 3;
    if (ua && ((op == 6) ? (rdy_t[sa] >= c) : (rdy_t[sa] > c))) return 4;
    if (ub && rdy_t[sb] > c) return 4;
    if (op != 6 && rdy_t[d] > c) return 4;
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, expv);
    end
  endtask

  // called just after a falling edge with inputs driven; returns predicted fire
  task automatic do_cycle(output bit fired);
    int ec;
    string tag;
    logic [7:0] exp_rr;
    #2;
    ec = exp_cause(int'(in_op), int'(in_dst), int'(in_src_a), int'(in_src_b),
                   in_use_a, in_use_b, cyc);
    case (ec)
      1: tag = "R8";
      2: tag = "R5";
      3: tag = "R4";
      4: tag = (in_op == 3'd6) ? "R7" : "R6";
      default: tag = (in_op == 3'd4) ? "R3" : "R2";
    endcase
    check(in_ready == (ec == 0), tag, int'(in_ready), int'(ec == 0));
    check(issue_fire == (in_valid && ec == 0), "R1", int'(issue_fire), int'(in_valid && ec == 0));
    check(stall == (in_valid && ec != 0), "R1", int'(stall), int'(in_valid && ec != 0));
    check(int'(stall_cause) == (in_valid ? ec : 0), "R10", int'(stall_cause), in_valid ? ec : 0);
    for (int i = 0; i < 8; i++) exp_rr[i] = (rdy_t[i] == cyc);
    check(result_ready == exp_rr, "R9", int'(result_ready), int'(exp_rr));
    fired = in_valid && (ec == 0);
    if (fired) begin
      if (in_op != 3'd6) rdy_t[in_dst] = cyc + op_lat(int'(in_op));
      if (in_op == 3'd2) last_mul = cyc;
      if (in_op == 3'd6) last_st = cyc;
      if (in_op == 3'd5) last_div = cyc;
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(input int n);
    bit f;
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b0;
      do_cycle(f);
    end
  endtask

  // presents one operation and holds it until the model predicts issue
  task automatic send(input int op, input int d, input int sa, input int sb,
                      input bit ua, input bit ub, output int wait_cyc);
    bit f = 1'b0;
    int start = cyc;
    in_valid = 1'b1; in_op = 3'(op); in_dst = 3'(d);
    in_src_a = 3'(sa); in_src_b = 3'(sb); in_use_a = ua; in_use_b = ub;
    while (!f) do_cycle(f);
    wait_cyc = cyc - 1 - start;
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    #2;
    check(result_ready == 8'd0, "R11", int'(result_ready), 0);
    check(in_ready == 1'b1, "R11", int'(in_ready), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog expired at cycle %0d: actual 0 expected 1", cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int w;
    void'($urandom(32'd4242));
    model_reset();
    @(negedge clk);
    do_reset();
    @(negedge clk);

    // R3: load then dependent add issues next cycle
    send(4, 0, 0, 0, 0, 0, w);
    send(0, 1, 0, 0, 1, 0, w);
    check(w == 0, "R3", w, 0);
    // R2: dependent add waits for the 3-cycle result
    send(1, 2, 1, 0, 1, 0, w);
    check(w == 2, "R2", w, 2);
    // R4: back-to-back multiplies
    idle(4);
    send(2, 3, 0, 0, 0, 0, w);
    send(2, 4, 0, 0, 0, 0, w);
    check(w == 1, "R4", w, 1);
    // R7: store of a just-computed value, then R8 gap
    idle(4);
    send(0, 5, 0, 0, 0, 0, w);
    send(6, 0, 5, 0, 1, 0, w);
    check(w == 3, "R7", w, 3);
    send(0, 6, 0, 0, 0, 0, w);
    check(w == 1, "R8", w, 1);
    // R5: divide blocks following add, then a second divide
    idle(4);
    send(5, 7, 0, 0, 0, 0, w);
    send(0, 1, 0, 0, 0, 0, w);
    check(w == 36, "R5", w, 36);
    send(5, 2, 0, 0, 0, 0, w);
    check(w == 1, "R5", w, 1);
    // R6: write-after-write on the divide destination
    send(4, 2, 0, 0, 0, 0, w);
    check(w == 38, "R6", w, 38);
    // R11: mid-run reset discards pending state
    send(2, 3, 0, 0, 0, 0, w);
    @(negedge clk);
    cyc++;
    do_reset();
    @(negedge clk);
    cyc++;
    send(2, 3, 3, 0, 1, 0, w);
    check(w == 0, "R11", w, 0);

    // random traffic
    for (int n = 0; n < 1500; n++) begin
      int r, op;
      r = int'($urandom_range(0, 99));
      if (r < 3) op = 5;
      else if (r < 20) op = 6;
      else if (r < 40) op = 2;
      else if (r < 55) op = 4;
      else op = int'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
      send(op, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), w);
    end
    idle(45);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule